// File: doc/BRIEF.md
# Reversible-Cell Nibble-Decomposed Unsigned Multiplier

This block multiplies two unsigned operands of twice the nibble width (8 bits by default) and returns the full-width product (16 bits by default). It is purely combinational. Every logic function in it comes from three reversible cells. A two-line copy cell provides controlled-NOT behaviour. A three-line cell yields an AND on one output when its third input is tied low. A four-line cell yields the sum and carry of a full adder when its fourth input is tied low. No signal drives more than one cell input directly. Where a value is needed in several places, it first passes through a chain of copy cells. Cell outputs that carry no useful value are left as garbage wires.

Each operand is cut into a high and a low nibble. Four nibble multipliers form the low-low, low-high, high-low and high-high products. Inside each one, the three-line cells form the partial-product bits and rows of four-line cells accumulate them. Three ripple adders built from four-line cells then combine the four sub-products. The low-low product sits at weight one, the two cross products at the nibble weight, and the high-high product at twice the nibble weight.

Top module: `rgm_mul`

## Requirements
- R1: For every pair of unsigned operands, prod_o equals opa_i multiplied by opb_i, all 2*NIB_W+2*NIB_W product bits included.
- R2: The three-line cell drives p = x, q = x xor y and r = (x and y) xor z for all eight input combinations.
- R3: The four-line cell drives p = w, q = x, r = w xor x xor y and s = ((w xor x) and y) xor ((w and x) xor z) for all sixteen input combinations.
- R4: The copy cell drives p = x and q = x xor y for all four input combinations, so y = 0 makes q a copy of x.
- R5: The nibble multiplier, given two NIB_W-bit operands, returns their full 2*NIB_W-bit unsigned product.
- R6: The ripple adder of W four-line cells returns sum and carry-out equal to a + b + carry-in, with carry-out as bit W of that total.
- R7: Bits [NIB_W-1:0] of prod_o equal the low NIB_W bits of (opa_i[NIB_W-1:0] times opb_i[NIB_W-1:0]), whatever the high nibbles hold.
- R8: When either operand is zero, prod_o is zero.
- R9: The fan-out block's every copy output equals its source vector, for every source value.
- R10: With both operands at their all-ones maximum, prod_o equals (2^(2*NIB_W) - 1)^2, which is 0xFE01 at the default width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 2*NIB_W (8) | Unsigned multiplicand |
| opb_i | input | 2*NIB_W (8) | Unsigned multiplier |
| prod_o | output | 4*NIB_W (16) | Unsigned product |

## Verification
The bound checks compare the product and the four internal sub-products against arithmetic references. They are evaluated combinationally, so they assume the operands are fully known two-state values and that each check runs only after the cell network has settled for the present operands. The stimulus keeps to this. It drives only defined bit patterns and holds each operand pair steady for a time step before any comparison. It sweeps the complete operand space at the default width, so every one of the nibble combinations reaches the adder tree.

// File: rtl/rgm_pkg.sv
package rgm_pkg;

   localparam int unsigned RGM_NIB_DEFAULT = 4;

   function automatic int unsigned rgm_op_width(input int unsigned nib);
      return 2 * nib;
   endfunction

   function automatic int unsigned rgm_prod_width(input int unsigned nib);
      return 4 * nib;
   endfunction

endpackage

// File: rtl/rgm_feynman.sv
// Two-line controlled-NOT cell: p follows x, q = x xor y.
module rgm_feynman (
   input  logic x_i,
   input  logic y_i,
   output logic p_o,
   output logic q_o
);
   assign p_o = x_i;
   assign q_o = x_i ^ y_i;
endmodule

// File: rtl/rgm_peres.sv
// Three-line cell: with z tied low, r is the AND of x and y.
module rgm_peres (
   input  logic x_i,
   input  logic y_i,
   input  logic z_i,
   output logic p_o,
   output logic q_o,
   output logic r_o
);
   assign p_o = x_i;
   assign q_o = x_i ^ y_i;
   assign r_o = (x_i & y_i) ^ z_i;
endmodule

// File: rtl/rgm_hng.sv
// Four-line cell: with z tied low, r is the full-adder sum, s the carry.
module rgm_hng (
   input  logic w_i,
   input  logic x_i,
   input  logic y_i,
   input  logic z_i,
   output logic p_o,
   output logic q_o,
   output logic r_o,
   output logic s_o
);
   logic wx_x;
   assign wx_x = w_i ^ x_i;
   assign p_o  = w_i;
   assign q_o  = x_i;
   assign r_o  = wx_x ^ y_i;
   assign s_o  = (wx_x & y_i) ^ ((w_i & x_i) ^ z_i);
endmodule

// File: rtl/rgm_fanout.sv
// Produces COPIES copies of a W-bit vector through chains of copy cells,
// so each source and intermediate wire feeds exactly one cell input.
module rgm_fanout #(
   parameter int unsigned W      = 4,
   parameter int unsigned COPIES = 2
) (
   input  logic [W-1:0]             src_i,
   output logic [COPIES-1:0][W-1:0] copy_o
);
   if (W < 1) begin : g_bad_w
      $error("rgm_fanout: W must be at least 1");
   end
   if (COPIES < 1) begin : g_bad_copies
      $error("rgm_fanout: COPIES must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (COPIES == 1) begin : g_single
         assign copy_o[0][b] = src_i[b];
      end else begin : g_chain
         logic [COPIES-1:0] chain;
         assign chain[0] = src_i[b];
         for (genvar k = 0; k < COPIES - 1; k++) begin : g_cell
            rgm_feynman u_cp (
               .x_i (chain[k]),
               .y_i (1'b0),
               .p_o (chain[k+1]),
               .q_o (copy_o[k][b])
            );
         end
         assign copy_o[COPIES-1][b] = chain[COPIES-1];
      end
   end
endmodule

// File: rtl/rgm_ripple.sv
// W-bit ripple-carry adder; each stage is one four-line cell with z low.
module rgm_ripple #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         c_i,
   output logic [W-1:0] sum_o,
   output logic         c_o
);
   if (W < 1) begin : g_bad_w
      $error("rgm_ripple: W must be at least 1");
   end

   logic [W:0]   carry;
   logic [W-1:0] stage_unused_p;
   logic [W-1:0] stage_unused_q;

   assign carry[0] = c_i;

   for (genvar k = 0; k < W; k++) begin : g_stage
      rgm_hng u_fa (
         .w_i (a_i[k]),
         .x_i (b_i[k]),
         .y_i (carry[k]),
         .z_i (1'b0),
         .p_o (stage_unused_p[k]),
         .q_o (stage_unused_q[k]),
         .r_o (sum_o[k]),
         .s_o (carry[k+1])
      );
   end

   assign c_o = carry[W];
endmodule

// File: rtl/rgm_mulnib.sv
// N x N unsigned array multiplier: three-line cells form the partial
// products, one N-bit ripple adder per row accumulates them.
module rgm_mulnib #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]   a_i,
   input  logic [N-1:0]   b_i,
   output logic [2*N-1:0] p_o
);
   if (N < 2) begin : g_bad_n
      $error("rgm_mulnib: N must be at least 2");
   end

   // a_cp[copy][bit], b_cp[copy][bit]
   logic [N-1:0][N-1:0] a_cp;
   logic [N-1:0][N-1:0] b_cp;

   rgm_fanout #(.W(N), .COPIES(N)) u_fan_a (.src_i(a_i), .copy_o(a_cp));
   rgm_fanout #(.W(N), .COPIES(N)) u_fan_b (.src_i(b_i), .copy_o(b_cp));

   // pp[row i][col j] = a[j] & b[i]; row i takes copy i of a, column j
   // takes copy j of b, so every copy wire is read once.
   logic [N-1:0][N-1:0] pp;
   logic [N-1:0][N-1:0] pp_unused_p;
   logic [N-1:0][N-1:0] pp_unused_q;

   for (genvar i = 0; i < N; i++) begin : g_row_pp
      for (genvar j = 0; j < N; j++) begin : g_col_pp
         rgm_peres u_and (
            .x_i (a_cp[i][j]),
            .y_i (b_cp[j][i]),
            .z_i (1'b0),
            .p_o (pp_unused_p[i][j]),
            .q_o (pp_unused_q[i][j]),
            .r_o (pp[i][j])
         );
      end
   end

   // Row accumulation: each row adds the running sum shifted down by one.
   logic [N-1:0][N-1:0] row_s;
   logic [N-1:0]        row_c;

   assign row_s[0] = pp[0];
   assign row_c[0] = 1'b0;

   for (genvar i = 1; i < N; i++) begin : g_row_add
      rgm_ripple #(.W(N)) u_row (
         .a_i   (pp[i]),
         .b_i   ({row_c[i-1], row_s[i-1][N-1:1]}),
         .c_i   (1'b0),
         .sum_o (row_s[i]),
         .c_o   (row_c[i])
      );
   end

   for (genvar i = 0; i < N; i++) begin : g_low_bits
      assign p_o[i] = row_s[i][0];
   end

   assign p_o[2*N-1:N] = {row_c[N-1], row_s[N-1][N-1:1]};
endmodule

// File: rtl/rgm_mul.sv
// Top: splits each operand into two nibbles, forms four nibble products
// and merges them with three ripple adders of four-line cells.
module rgm_mul #(
   parameter int unsigned NIB_W = rgm_pkg::RGM_NIB_DEFAULT
) (
   input  logic [rgm_pkg::rgm_op_width(NIB_W)-1:0]   opa_i,
   input  logic [rgm_pkg::rgm_op_width(NIB_W)-1:0]   opb_i,
   output logic [rgm_pkg::rgm_prod_width(NIB_W)-1:0] prod_o
);
   localparam int unsigned OP_W = rgm_pkg::rgm_op_width(NIB_W);
   localparam int unsigned SP_W = 2 * NIB_W;

   if (NIB_W < 2) begin : g_bad_nib
      $error("rgm_mul: NIB_W must be at least 2");
   end

   // Two copies of each operand: copy 0 and copy 1 each go to two
   // different nibble multipliers, one nibble apiece.
   logic [1:0][OP_W-1:0] a_cp;
   logic [1:0][OP_W-1:0] b_cp;

   rgm_fanout #(.W(OP_W), .COPIES(2)) u_fan_a (.src_i(opa_i), .copy_o(a_cp));
   rgm_fanout #(.W(OP_W), .COPIES(2)) u_fan_b (.src_i(opb_i), .copy_o(b_cp));

   logic [SP_W-1:0] sp_ll;
   logic [SP_W-1:0] sp_lh;
   logic [SP_W-1:0] sp_hl;
   logic [SP_W-1:0] sp_hh;

   rgm_mulnib #(.N(NIB_W)) u_ll (
      .a_i (a_cp[0][NIB_W-1:0]),
      .b_i (b_cp[0][NIB_W-1:0]),
      .p_o (sp_ll)
   );
   rgm_mulnib #(.N(NIB_W)) u_lh (
      .a_i (a_cp[1][NIB_W-1:0]),
      .b_i (b_cp[0][OP_W-1:NIB_W]),
      .p_o (sp_lh)
   );
   rgm_mulnib #(.N(NIB_W)) u_hl (
      .a_i (a_cp[0][OP_W-1:NIB_W]),
      .b_i (b_cp[1][NIB_W-1:0]),
      .p_o (sp_hl)
   );
   rgm_mulnib #(.N(NIB_W)) u_hh (
      .a_i (a_cp[1][OP_W-1:NIB_W]),
      .b_i (b_cp[1][OP_W-1:NIB_W]),
      .p_o (sp_hh)
   );

   // Sum of the two cross products.
   logic [SP_W-1:0] cross_s;
   logic            cross_c;

   rgm_ripple #(.W(SP_W)) u_add_cross (
      .a_i   (sp_lh),
      .b_i   (sp_hl),
      .c_i   (1'b0),
      .sum_o (cross_s),
      .c_o   (cross_c)
   );

   // Middle span, bits [3N-1:N]: upper half of low-low, lower half of
   // high-high, plus the cross sum.
   logic mid_c;

   rgm_ripple #(.W(SP_W)) u_add_mid (
      .a_i   ({sp_hh[NIB_W-1:0], sp_ll[SP_W-1:NIB_W]}),
      .b_i   (cross_s),
      .c_i   (1'b0),
      .sum_o (prod_o[3*NIB_W-1:NIB_W]),
      .c_o   (mid_c)
   );

   // Top span, bits [4N-1:3N]: upper half of high-high plus both carries.
   logic top_unused_c;

   rgm_ripple #(.W(NIB_W)) u_add_top (
      .a_i   (sp_hh[SP_W-1:NIB_W]),
      .b_i   ({{(NIB_W-1){1'b0}}, cross_c}),
      .c_i   (mid_c),
      .sum_o (prod_o[4*NIB_W-1:3*NIB_W]),
      .c_o   (top_unused_c)
   );

   assign prod_o[NIB_W-1:0] = sp_ll[NIB_W-1:0];
endmodule

// File: rtl/rgm_mul_chk.sv
// Checker bound to rgm_mul; compares settled values against arithmetic.
module rgm_mul_chk #(
   parameter int unsigned NIB_W = 4
) (
   input logic [2*NIB_W-1:0] opa_i,
   input logic [2*NIB_W-1:0] opb_i,
   input logic [4*NIB_W-1:0] prod_o,
   input logic [2*NIB_W-1:0] sp_ll_i,
   input logic [2*NIB_W-1:0] sp_lh_i,
   input logic [2*NIB_W-1:0] sp_hl_i,
   input logic [2*NIB_W-1:0] sp_hh_i
);
   localparam int unsigned OP_W = 2 * NIB_W;
   localparam int unsigned PR_W = 4 * NIB_W;

   logic [NIB_W-1:0] a_lo, a_hi, b_lo, b_hi;
   assign a_lo = opa_i[NIB_W-1:0];
   assign a_hi = opa_i[OP_W-1:NIB_W];
   assign b_lo = opb_i[NIB_W-1:0];
   assign b_hi = opb_i[OP_W-1:NIB_W];

   always_comb begin
      a_r1_full_product: assert (prod_o == PR_W'(opa_i) * PR_W'(opb_i))
         else $error("R1 product mismatch");
      a_r5_sub_ll: assert (sp_ll_i == OP_W'(a_lo) * OP_W'(b_lo))
         else $error("R5 low-low sub-product mismatch");
      a_r5_sub_lh: assert (sp_lh_i == OP_W'(a_lo) * OP_W'(b_hi))
         else $error("R5 low-high sub-product mismatch");
      a_r5_sub_hl: assert (sp_hl_i == OP_W'(a_hi) * OP_W'(b_lo))
         else $error("R5 high-low sub-product mismatch");
      a_r5_sub_hh: assert (sp_hh_i == OP_W'(a_hi) * OP_W'(b_hi))
         else $error("R5 high-high sub-product mismatch");
      a_r7_low_nibble: assert (prod_o[NIB_W-1:0] == sp_ll_i[NIB_W-1:0])
         else $error("R7 low nibble mismatch");
      if (opa_i == '0 || opb_i == '0) begin
         a_r8_zero_operand: assert (prod_o == '0)
            else $error("R8 zero operand gave nonzero product");
      end
   end
endmodule

bind rgm_mul rgm_mul_chk #(.NIB_W(NIB_W)) u_chk (
   .opa_i   (opa_i),
   .opb_i   (opb_i),
   .prod_o  (prod_o),
   .sp_ll_i (sp_ll),
   .sp_lh_i (sp_lh),
   .sp_hl_i (sp_hl),
   .sp_hh_i (sp_hh)
);

// File: tb/tb_rgm_mul.sv
module tb_rgm_mul;
   localparam int CLK_PERIOD = 10;
   localparam int NIB        = 4;
   localparam int OPW        = 2 * NIB;
   localparam int PRW        = 4 * NIB;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   task automatic chk(input string tag, input longint unsigned act,
                      input longint unsigned exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Top
   logic [OPW-1:0] ta, tb;
   logic [PRW-1:0] tp;
   rgm_mul #(.NIB_W(NIB)) dut (.opa_i(ta), .opb_i(tb), .prod_o(tp));

   // Cells
   logic fx, fy, fp, fq;
   rgm_feynman u_fey (.x_i(fx), .y_i(fy), .p_o(fp), .q_o(fq));

   logic px, py, pz, pp, pq, pr;
   rgm_peres u_per (.x_i(px), .y_i(py), .z_i(pz), .p_o(pp), .q_o(pq), .r_o(pr));

   logic hw, hx, hy, hz, hp, hq, hr, hs;
   rgm_hng u_hng (.w_i(hw), .x_i(hx), .y_i(hy), .z_i(hz),
                  .p_o(hp), .q_o(hq), .r_o(hr), .s_o(hs));

   logic [OPW-1:0]        fan_src;
   logic [2:0][OPW-1:0]   fan_cp;
   rgm_fanout #(.W(OPW), .COPIES(3)) u_fan (.src_i(fan_src), .copy_o(fan_cp));

   logic [OPW-1:0] ad_a, ad_b, ad_s;
   logic           ad_ci, ad_co;
   rgm_ripple #(.W(OPW)) u_add (.a_i(ad_a), .b_i(ad_b), .c_i(ad_ci),
                                .sum_o(ad_s), .c_o(ad_co));

   logic [NIB-1:0] na, nb;
   logic [OPW-1:0] np;
   rgm_mulnib #(.N(NIB)) u_nib (.a_i(na), .b_i(nb), .p_o(np));

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      if (!done) begin
         cycles++;
         if (cycles > WATCHDOG) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            summary();
            $finish;
         end
      end
   end

   initial begin
      ta = '0; tb = '0; fx = 0; fy = 0; px = 0; py = 0; pz = 0;
      hw = 0; hx = 0; hy = 0; hz = 0; fan_src = '0;
      ad_a = '0; ad_b = '0; ad_ci = 0; na = '0; nb = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      #2;
      // Initial state with both operands zero (R8)
      chk("R8 initial zero product", tp, 0);

      // R4 copy cell truth table
      for (int v = 0; v < 4; v++) begin
         fx = v[1]; fy = v[0];
         #1;
         chk("R4 copy cell p", fp, v[1]);
         chk("R4 copy cell q", fq, v[1] ^ v[0]);
      end

      // R2 three-line cell truth table
      for (int v = 0; v < 8; v++) begin
         px = v[2]; py = v[1]; pz = v[0];
         #1;
         chk("R2 three-line p", pp, v[2]);
         chk("R2 three-line q", pq, v[2] ^ v[1]);
         chk("R2 three-line r", pr, (v[2] & v[1]) ^ v[0]);
      end

      // R3 four-line cell truth table
      for (int v = 0; v < 16; v++) begin
         hw = v[3]; hx = v[2]; hy = v[1]; hz = v[0];
         #1;
         chk("R3 four-line p", hp, v[3]);
         chk("R3 four-line q", hq, v[2]);
         chk("R3 four-line r", hr, v[3] ^ v[2] ^ v[1]);
         chk("R3 four-line s", hs, ((v[3] ^ v[2]) & v[1]) ^ ((v[3] & v[2]) ^ v[0]));
      end

      // R9 fan-out copies
      for (int v = 0; v < 256; v++) begin
         fan_src = OPW'(v);
         #1;
         for (int c = 0; c < 3; c++) chk("R9 fan-out copy", fan_cp[c], v);
      end

      // R6 ripple adder
      for (int a = 0; a < 256; a += 7) begin
         for (int b = 0; b < 256; b++) begin
            for (int ci = 0; ci < 2; ci++) begin
               ad_a = OPW'(a); ad_b = OPW'(b); ad_ci = ci[0];
               #1;
               chk("R6 adder total", {ad_co, ad_s}, a + b + ci);
            end
         end
      end

      // R5 nibble multiplier, exhaustive
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            na = NIB'(a); nb = NIB'(b);
            #1;
            chk("R5 nibble product", np, a * b);
         end
      end

      // R1, R7, R8: full multiplier, exhaustive
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            ta = OPW'(a); tb = OPW'(b);
            #1;
            chk("R1 full product", tp, a * b);
            chk("R7 low nibble", tp[NIB-1:0], ((a % 16) * (b % 16)) % 16);
            if (a == 0 || b == 0) chk("R8 zero operand", tp, 0);
         end
      end

      // R10 maximum operands
      ta = '1; tb = '1;
      #1;
      chk("R10 max operands", tp, 16'hFE01);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule